// File: doc/BRIEF.md
# Serial Subcarrier Increment Frame Receiver

This block listens to a one-bit control line that a companion video decoder drives, one sample per pixel clock, to keep an encoder's colour subcarrier in step with the incoming video. Samples count only in clock cycles where the sample-enable input is high. The receiver first waits for the line to sit low for a minimum run of samples. It then takes a high sample as the start mark and collects a fixed-length payload. From the payload it extracts a 22-bit subcarrier increment, a line-sequence flag and a synthesizer-reset flag.

When the last payload bit arrives, the block builds a 32-bit phase-increment word for a direct digital synthesizer. The received increment fills bits 31:10. A fixed low-order constant, `FREQ_LOW`, which is zero in this mode, fills bits 9:0. The word is presented with a one-cycle load strobe. The sequence flag is held on `seq_out`. For PAL, 1 marks an inverted line and 0 a normal one; for NTSC the value 0 means no change. A set reset flag produces a one-cycle `dds_rst` pulse alongside the strobe. A frame that stalls because the enable stays low for too long is thrown away, and nothing is loaded.

The controller has four states:
- `ST_HUNT` counts consecutive low samples and moves to `ST_ARMED` once `LOW_MIN` of them have been seen.
- `ST_ARMED` moves to `ST_SHIFT` on the first enabled high sample.
- `ST_SHIFT` moves to `ST_DONE` on the last payload bit. It returns to `ST_HUNT` on a stall timeout.
- `ST_DONE` always returns to `ST_HUNT`.

Top module: `sc_frame_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `load_stb`, `dds_rst`, `seq_out` and `inc_word` are all 0 until a frame completes.
- R2: A start mark (enabled high sample) is accepted only after at least `LOW_MIN` (default 8) consecutive enabled low samples. A run of `LOW_MIN`-1 lows does not start a frame.
- R3: After the start mark, the payload is 33 enabled samples in this order: increment bits 21 down to 0 (most significant first), 4 reserved bits, the sequence bit, the reset bit, then 5 reserved bits.
- R4: The loaded word has the received increment in bits 31:10 and `FREQ_LOW` (default 0) in bits 9:0.
- R5: `load_stb` is high for exactly one cycle, the cycle after the edge that samples the 33rd payload bit. `inc_word` changes only at that point.
- R6: `seq_out` takes the sequence bit of each completed frame and keeps it until the next completed frame.
- R7: `dds_rst` pulses for one cycle together with `load_stb` only when the completed frame's reset bit is 1.
- R8: The values of the reserved bits have no effect on any output.
- R9: Cycles with `sample_en` low are not sampled. `GAP_MAX` (default 4) consecutive such cycles inside a payload abort the frame: no strobe, no reset pulse, outputs unchanged. Fewer than that are tolerated.
- R10: After a frame completes or aborts, a fresh low run of `LOW_MIN` samples is needed before the next start mark is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial control line |
| sample_en | input | 1 | High in cycles where `sdata` holds a valid sample |
| inc_word | output | 32 | Phase-increment word for the synthesizer |
| load_stb | output | 1 | One-cycle strobe to load `inc_word` |
| seq_out | output | 1 | Sequence flag of the last completed frame |
| dds_rst | output | 1 | One-cycle synthesizer accumulator reset pulse |

## Verification
The hardest situation to reach from the ports is the stall abort at its exact boundary. A gap of `GAP_MAX`-1 disabled cycles must still load, while one more disabled cycle must drop the frame. Both cases also have to avoid leaving a stray low run that re-arms the receiver. The stimulus inserts controlled gaps at a chosen payload position, using all-ones increments so the abandoned payload cannot fake a start. The same care applies to the low-run boundary of `LOW_MIN`-1 versus `LOW_MIN` samples, where a high sample is sent first to clear any earlier run. A behavioural queue model in the bench predicts every output on every clock.

// File: rtl/scfr_pkg.sv
package scfr_pkg;
    // Field layout of a received frame (positions counted from the first payload bit)
    localparam int INC_W      = 22;
    localparam int RES_A_W    = 4;
    localparam int RES_B_W    = 5;
    localparam int SEQ_POS    = INC_W + RES_A_W;
    localparam int RST_POS    = SEQ_POS + 1;
    localparam int FRAME_BITS = RST_POS + 1 + RES_B_W;
    localparam int WORD_W     = 32;
    localparam int LOW_W      = WORD_W - INC_W;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/scfr_lowrun.sv
module scfr_lowrun #(
    parameter int LOW_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic smp,
    input  logic din,
    output logic run_done
);
    localparam int RW = $clog2(LOW_MIN + 1);

    logic [RW-1:0] run_q;

    // The sample that completes the required run of lows
    assign run_done = count_en && smp && !din && (run_q == RW'(LOW_MIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!count_en) begin
            run_q <= '0;
        end else if (smp) begin
            if (din) begin
                run_q <= '0;
            end else if (!run_done) begin
                run_q <= run_q + RW'(1);
            end
        end
    end
endmodule

// File: rtl/scfr_shifter.sv
module scfr_shifter
    import scfr_pkg::*;
#(
    parameter int GAP_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             smp,
    input  logic             din,
    output logic             last_bit,
    output logic             gap_expire,
    output logic [INC_W-1:0] inc_f,
    output logic             seq_f,
    output logic             rst_f
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam int GW = $clog2(GAP_MAX + 1);

    logic [CW-1:0] bit_cnt;
    logic [GW-1:0] gap_cnt;

    assign last_bit   = active && smp && (bit_cnt == CW'(FRAME_BITS - 1));
    assign gap_expire = active && !smp && (gap_cnt == GW'(GAP_MAX - 1));

    // Only the kept fields are stored; reserved positions are never captured
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            gap_cnt <= '0;
            inc_f   <= '0;
            seq_f   <= 1'b0;
            rst_f   <= 1'b0;
        end else if (start) begin
            bit_cnt <= '0;
            gap_cnt <= '0;
            inc_f   <= '0;
            seq_f   <= 1'b0;
            rst_f   <= 1'b0;
        end else if (active) begin
            if (smp) begin
                bit_cnt <= bit_cnt + CW'(1);
                gap_cnt <= '0;
                for (int i = 0; i < INC_W; i++) begin
                    if (bit_cnt == CW'(i)) begin
                        inc_f[INC_W-1-i] <= din;
                    end
                end
                if (bit_cnt == CW'(SEQ_POS)) begin
                    seq_f <= din;
                end
                if (bit_cnt == CW'(RST_POS)) begin
                    rst_f <= din;
                end
            end else begin
                gap_cnt <= gap_cnt + GW'(1);
            end
        end
    end
endmodule

// File: rtl/scfr_decode.sv
module scfr_decode
    import scfr_pkg::*;
#(
    parameter logic [LOW_W-1:0] FREQ_LOW = '0
) (
    input  logic [INC_W-1:0]  inc_f,
    input  logic              seq_f,
    input  logic              rst_f,
    output logic [WORD_W-1:0] word,
    output logic              seq_v,
    output logic              rst_v
);
    always_comb begin
        word  = {inc_f, FREQ_LOW};
        seq_v = seq_f;
        rst_v = rst_f;
    end
endmodule

// File: rtl/sc_frame_rx.sv
module sc_frame_rx
    import scfr_pkg::*;
#(
    parameter int                LOW_MIN  = 8,
    parameter int                GAP_MAX  = 4,
    parameter logic [LOW_W-1:0]  FREQ_LOW = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              sample_en,
    output logic [WORD_W-1:0] inc_word,
    output logic              load_stb,
    output logic              seq_out,
    output logic              dds_rst
);
    rx_state_t state_q, state_d;

    logic run_done, start, last_bit, gap_expire;
    logic [INC_W-1:0]  inc_f;
    logic              seq_f, rst_f, seq_v, rst_v;
    logic [WORD_W-1:0] word_v;

    assign start = (state_q == ST_ARMED) && sample_en && sdata;

    scfr_lowrun #(.LOW_MIN(LOW_MIN)) lowrun_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (state_q == ST_HUNT),
        .smp      (sample_en),
        .din      (sdata),
        .run_done (run_done)
    );

    scfr_shifter #(.GAP_MAX(GAP_MAX)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .active     (state_q == ST_SHIFT),
        .smp        (sample_en),
        .din        (sdata),
        .last_bit   (last_bit),
        .gap_expire (gap_expire),
        .inc_f      (inc_f),
        .seq_f      (seq_f),
        .rst_f      (rst_f)
    );

    scfr_decode #(.FREQ_LOW(FREQ_LOW)) dec_i (
        .inc_f (inc_f),
        .seq_f (seq_f),
        .rst_f (rst_f),
        .word  (word_v),
        .seq_v (seq_v),
        .rst_v (rst_v)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (run_done) state_d = ST_ARMED;
            ST_ARMED: if (start)    state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (last_bit)        state_d = ST_DONE;
                else if (gap_expire) state_d = ST_HUNT;
            end
            ST_DONE:  state_d = ST_HUNT;
            default:  state_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Output register: the final payload bit is reserved, so all kept fields are ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_word <= '0;
            load_stb <= 1'b0;
            seq_out  <= 1'b0;
            dds_rst  <= 1'b0;
        end else begin
            load_stb <= 1'b0;
            dds_rst  <= 1'b0;
            if (state_q == ST_SHIFT && last_bit) begin
                inc_word <= word_v;
                load_stb <= 1'b1;
                seq_out  <= seq_v;
                dds_rst  <= rst_v;
            end
        end
    end
endmodule

// File: rtl/sc_frame_rx_chk.sv
module sc_frame_rx_chk #(
    parameter int               LW       = 10,
    parameter logic [LW-1:0]    FREQ_LOW = '0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sample_en,
    input logic [31:0] inc_word,
    input logic        load_stb,
    input logic        seq_out,
    input logic        dds_rst
);
    p_stb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |-> $stable(inc_word));

    p_low_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (inc_word[LW-1:0] == FREQ_LOW));

    p_seq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |-> $stable(seq_out));

    p_rst_with_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dds_rst |-> load_stb);

    p_last_sampled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_stb) |-> $past(sample_en));
endmodule

bind sc_frame_rx sc_frame_rx_chk #(.LW(scfr_pkg::LOW_W), .FREQ_LOW(FREQ_LOW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .inc_word  (inc_word),
    .load_stb  (load_stb),
    .seq_out   (seq_out),
    .dds_rst   (dds_rst)
);

// File: tb/sc_frame_rx_tb_top.sv
`timescale 1ns/1ps
module sc_frame_rx_tb_top;
    localparam int LOW_MIN = 8;
    localparam int GAP_MAX = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b0;
    logic        sample_en = 1'b0;
    logic [31:0] inc_word;
    logic        load_stb, seq_out, dds_rst;

    always #10 clk = ~clk;

    sc_frame_rx #(.LOW_MIN(LOW_MIN), .GAP_MAX(GAP_MAX), .FREQ_LOW(10'h000)) dut_i (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .sample_en(sample_en),
        .inc_word(inc_word), .load_stb(load_stb), .seq_out(seq_out), .dds_rst(dds_rst)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // Behavioural reference model
    int   m_st = 0;
    int   m_low = 0;
    int   m_gap = 0;
    bit   m_q[$];
    logic [31:0] e_word = '0;
    logic        e_stb = 0, e_seq = 0, e_rst = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_low = 0; m_gap = 0; m_q.delete();
            e_word = '0; e_stb = 0; e_seq = 0; e_rst = 0;
        end else begin
            e_stb = 0; e_rst = 0;
            case (m_st)
                0: if (sample_en) begin
                       if (!sdata) begin
                           if (m_low == LOW_MIN - 1) m_st = 1;
                           else m_low++;
                       end else m_low = 0;
                   end
                1: if (sample_en && sdata) begin
                       m_st = 2; m_q.delete(); m_gap = 0;
                   end
                2: if (sample_en) begin
                       m_q.push_back(sdata);
                       m_gap = 0;
                       if (m_q.size() == 33) begin
                           logic [21:0] v;
                           v = '0;
                           for (int i = 0; i < 22; i++) v = {v[20:0], m_q[i]};
                           e_word = {v, 10'h000};
                           e_seq = m_q[26];
                           e_rst = m_q[27];
                           e_stb = 1;
                           m_st = 3;
                       end
                   end else begin
                       m_gap++;
                       if (m_gap == GAP_MAX) begin m_st = 0; m_low = 0; end
                   end
                default: begin m_st = 0; m_low = 0; end
            endcase
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Observed loads
    int          loads = 0;
    logic [31:0] l_word = '0;
    logic        l_seq = 0, l_rst = 0;
    int          rst_pulses = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5 load_stb", {31'b0, load_stb}, {31'b0, e_stb});
            check("R4 inc_word", inc_word, e_word);
            check("R6 seq_out", {31'b0, seq_out}, {31'b0, e_seq});
            check("R7 dds_rst", {31'b0, dds_rst}, {31'b0, e_rst});
            if (load_stb) begin
                loads++;
                l_word = inc_word; l_seq = seq_out; l_rst = dds_rst;
            end
            if (dds_rst) rst_pulses++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog all-R act=timeout exp=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        sample_en = 1'b1;
        sdata = b;
    endtask

    task automatic idle_low(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic no_sample(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_en = 1'b0;
            sdata = i[0];
        end
    endtask

    task automatic send_frame(input logic [21:0] inc, input logic sq, input logic rs,
                              input logic [3:0] ra, input logic [4:0] rb,
                              input int gap_at, input int gap_len);
        logic [32:0] f;
        f = {inc, ra, sq, rs, rb};
        send_bit(1'b1);
        for (int i = 0; i < 33; i++) begin
            if (i == gap_at) no_sample(gap_len);
            send_bit(f[32-i]);
        end
    endtask

    initial begin
        int n0;
        int p0;
        repeat (3) @(negedge clk);
        check("R1 reset load_stb", {31'b0, load_stb}, 32'd0);
        check("R1 reset inc_word", inc_word, 32'd0);
        check("R1 reset seq/rst", {30'b0, seq_out, dds_rst}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {inc_word[29:0], seq_out, load_stb}, 32'd0);

        // Basic frame
        idle_low(10);
        send_frame(22'h2AB5C3, 1'b1, 1'b0, 4'h0, 5'h00, -1, 0);
        idle_low(2);
        check("R3 one load", loads, 1);
        check("R4 word layout", l_word, {22'h2AB5C3, 10'h000});
        check("R6 seq taken", {31'b0, l_seq}, 32'd1);
        check("R7 no reset pulse", rst_pulses, 0);

        // Reset bit set, reserved bits all ones
        idle_low(10);
        send_frame(22'h012345, 1'b0, 1'b1, 4'hF, 5'h1F, -1, 0);
        idle_low(2);
        check("R7 reset pulse", rst_pulses, 1);
        check("R3 word B", l_word, {22'h012345, 10'h000});
        // Same frame, reserved zeros
        idle_low(10);
        send_frame(22'h012345, 1'b0, 1'b1, 4'h0, 5'h00, -1, 0);
        idle_low(2);
        check("R8 reserved ignored word", l_word, {22'h012345, 10'h000});
        check("R8 reserved ignored seq", {31'b0, l_seq}, 32'd0);
        // Reserved ones must not fake a reset
        idle_low(10);
        send_frame(22'h3A5A5A, 1'b1, 1'b0, 4'hF, 5'h1F, -1, 0);
        idle_low(2);
        check("R8 reserved no reset", rst_pulses, 2);
        check("R8 loads so far", loads, 4);

        // Low run one short
        n0 = loads;
        send_bit(1'b1);
        idle_low(LOW_MIN - 1);
        send_frame(22'h3FFFFF, 1'b1, 1'b1, 4'h0, 5'h00, -1, 0);
        send_bit(1'b1);
        idle_low(2);
        check("R2 short run no load", loads, n0);
        // Exact minimum run
        send_bit(1'b1);
        idle_low(LOW_MIN);
        send_frame(22'h3C0F1E, 1'b0, 1'b0, 4'h0, 5'h00, -1, 0);
        idle_low(2);
        check("R2 exact run loads", loads, n0 + 1);
        check("R2 exact run word", l_word, {22'h3C0F1E, 10'h000});

        // Tolerated gap
        idle_low(10);
        send_frame(22'h2D2D2D, 1'b1, 1'b0, 4'h0, 5'h00, 5, GAP_MAX - 1);
        idle_low(2);
        check("R9 short gap loads", loads, n0 + 2);
        check("R9 short gap word", l_word, {22'h2D2D2D, 10'h000});
        // Aborting gap
        n0 = loads;
        p0 = rst_pulses;
        idle_low(10);
        send_frame(22'h3FFFFF, 1'b0, 1'b1, 4'h0, 5'h00, 5, GAP_MAX);
        send_bit(1'b1);
        idle_low(2);
        check("R9 abort no load", loads, n0);
        check("R9 abort no reset", rst_pulses, p0);
        check("R9 abort seq kept", {31'b0, seq_out}, 32'd1);
        check("R9 abort word kept", inc_word, {22'h2D2D2D, 10'h000});

        // Back-to-back frames without a fresh low run
        n0 = loads;
        idle_low(10);
        send_frame(22'h3FFFFF, 1'b0, 1'b0, 4'h0, 5'h00, -1, 0);
        send_frame(22'h3FFFFF, 1'b1, 1'b0, 4'h0, 5'h00, -1, 0);
        idle_low(3);
        check("R10 second frame ignored", loads, n0 + 1);
        check("R10 seq from first", {31'b0, seq_out}, 32'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule